// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast reference enable into a serial bit-rate tick. A divisor made of a 14-bit integer part and a 3-bit fractional part in eighths sets the average spacing of the ticks to (N + M/8) reference pulses. The fraction comes from a small phase accumulator. Each baud period therefore lasts either N or N+1 reference pulses, and any run of eight periods adds up to exactly 8N+M. A reference of 3 MHz gives 3 MHz / (N + M/8).

The integer field has two reserved codes for the fastest rates. Code 0 gives one tick per reference pulse. Code 1 gives one tick every third reference pulse. A separate wide flag makes code 0 mean a divisor of 16384, which does not fit in 14 bits. A new divisor is captured by a load strobe. It takes effect only at the next period boundary, so the period already running is never cut short. The block has no data stream: all inputs and the tick output are plain control pins with no handshake and no back-pressure.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `baud_tick` is low and the divisor is integer 16 with fraction 0, so the first periods last 16 reference pulses.
- R2: `baud_tick` is a one-clock pulse, asserted in the clock after the `ref_en` pulse that completes a period. Clocks without `ref_en` never advance a period, so with `ref_en` held low no tick appears.
- R3: For an integer code from 2 to 16383 with fraction 0, every period is exactly N reference pulses.
- R4: For a fraction M from 1 to 7, the accumulator adds M once per period, and a carry out of its 3 bits adds one pulse to that period. Every period is N or N+1, and every 8 consecutive periods total exactly 8N+M.
- R5: Integer code 0 with the wide flag low gives a period of 1 reference pulse, and the fraction is ignored.
- R6: Integer code 1 gives a period of 3 reference pulses, and the fraction is ignored.
- R7: Integer code 0 with the wide flag high gives a divisor of 16384 plus the fractional part.
- R8: A loaded divisor first applies to the period that starts at the next boundary, and the period in progress keeps its length. Changes on the divisor inputs without `cfg_load` have no effect.
- R9: A load in the same clock as the completing `ref_en` pulse applies to the period that starts at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-clock reference-rate enable pulse |
| cfg_int | input | 14 | Integer divisor code (0 and 1 reserved) |
| cfg_frac | input | 3 | Fractional divisor in eighths |
| cfg_wide | input | 1 | Makes integer code 0 mean 16384 |
| cfg_load | input | 1 | Captures the divisor inputs |
| baud_tick | output | 1 | One-clock baud tick |

## Verification
A tick is due one clock after the `ref_en` pulse that completes a period, and a load applies at the first boundary after it. The bench samples on the falling edge and measures each period as the number of `ref_en` pulses seen since the previous tick. This makes every result independent of the `ref_en` gap. The driver issues each load one clock after the tick that starts the last expected period of the previous setting. With a 2-pulse period and back-to-back enables, that load lands on the completing pulse itself.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  typedef enum logic [1:0] {
    RATE_REF   = 2'd0,
    RATE_THIRD = 2'd1,
    RATE_FRAC  = 2'd2
  } rate_mode_e;

endpackage

// File: rtl/baud_cfg_hold.sv
module baud_cfg_hold #(
  parameter int INT_W   = 14,
  parameter int FRAC_W  = 3,
  parameter int RST_INT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INT_W-1:0]  in_int,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic              in_wide,
  output logic [INT_W-1:0]  sel_int,
  output logic [FRAC_W-1:0] sel_frac,
  output logic              sel_wide
);

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic              wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= INT_W'(RST_INT);
      frac_q <= '0;
      wide_q <= 1'b0;
    end else if (load) begin
      int_q  <= in_int;
      frac_q <= in_frac;
      wide_q <= in_wide;
    end
  end

  // a load arriving on a boundary clock bypasses the hold register
  always_comb begin
    sel_int  = load ? in_int  : int_q;
    sel_frac = load ? in_frac : frac_q;
    sel_wide = load ? in_wide : wide_q;
  end

endmodule

// File: rtl/baud_len_sel.sv
module baud_len_sel
  import frac_baud_pkg::*;
#(
  parameter int INT_W     = 14,
  parameter int FRAC_W    = 3,
  parameter int LEN_W     = INT_W + 1,
  parameter int THIRD_DIV = 3
) (
  input  logic [INT_W-1:0]  sel_int,
  input  logic [FRAC_W-1:0] sel_frac,
  input  logic              sel_wide,
  input  logic [FRAC_W-1:0] acc_in,
  output logic [LEN_W-1:0]  len_out,
  output logic [FRAC_W-1:0] acc_out
);

  localparam logic [LEN_W-1:0] WIDE_DIV = LEN_W'(1) << INT_W;

  rate_mode_e        mode;
  logic [FRAC_W:0]   sum;
  logic [LEN_W-1:0]  base;

  always_comb begin
    if (sel_int == '0 && !sel_wide)      mode = RATE_REF;
    else if (sel_int == INT_W'(1))       mode = RATE_THIRD;
    else                                 mode = RATE_FRAC;
  end

  always_comb begin
    sum  = {1'b0, acc_in} + {1'b0, sel_frac};
    base = (sel_int == '0) ? WIDE_DIV : LEN_W'(sel_int);
    unique case (mode)
      RATE_REF: begin
        len_out = LEN_W'(1);
        acc_out = acc_in;
      end
      RATE_THIRD: begin
        len_out = LEN_W'(THIRD_DIV);
        acc_out = acc_in;
      end
      default: begin
        len_out = base + LEN_W'(sum[FRAC_W]);
        acc_out = sum[FRAC_W-1:0];
      end
    endcase
  end

endmodule

// File: rtl/baud_tick_ctr.sv
module baud_tick_ctr #(
  parameter int LEN_W   = 15,
  parameter int FRAC_W  = 3,
  parameter int RST_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic [LEN_W-1:0]  next_len,
  input  logic [FRAC_W-1:0] next_acc,
  output logic              tick,
  output logic [LEN_W-1:0]  cnt_q,
  output logic [LEN_W-1:0]  cur_len,
  output logic [FRAC_W-1:0] acc_q
);

  logic boundary;

  assign boundary = ref_en && (cnt_q == cur_len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cur_len <= LEN_W'(RST_LEN);
      acc_q   <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= boundary;
      if (boundary) begin
        cnt_q   <= '0;
        cur_len <= next_len;
        acc_q   <= next_acc;
      end else if (ref_en) begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W     = 14,
  parameter int FRAC_W    = 3,
  parameter int THIRD_DIV = 3,
  parameter int RST_INT   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  logic              cfg_wide,
  input  logic              cfg_load,
  output logic              baud_tick
);

  localparam int LEN_W = INT_W + 1;

  logic [INT_W-1:0]  sel_int;
  logic [FRAC_W-1:0] sel_frac;
  logic              sel_wide;
  logic [LEN_W-1:0]  next_len;
  logic [FRAC_W-1:0] next_acc;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  cur_len;
  logic [FRAC_W-1:0] acc_q;

  baud_cfg_hold #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .RST_INT(RST_INT)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .in_int(cfg_int), .in_frac(cfg_frac), .in_wide(cfg_wide),
    .sel_int(sel_int), .sel_frac(sel_frac), .sel_wide(sel_wide)
  );

  baud_len_sel #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .LEN_W(LEN_W), .THIRD_DIV(THIRD_DIV)
  ) u_sel (
    .sel_int(sel_int), .sel_frac(sel_frac), .sel_wide(sel_wide),
    .acc_in(acc_q), .len_out(next_len), .acc_out(next_acc)
  );

  baud_tick_ctr #(
    .LEN_W(LEN_W), .FRAC_W(FRAC_W), .RST_LEN(RST_INT)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en),
    .next_len(next_len), .next_acc(next_acc),
    .tick(baud_tick), .cnt_q(cnt_q), .cur_len(cur_len), .acc_q(acc_q)
  );

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int LEN_W  = 15,
  parameter int FRAC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_en,
  input logic              baud_tick,
  input logic [LEN_W-1:0]  cnt_q,
  input logic [LEN_W-1:0]  cur_len,
  input logic [FRAC_W-1:0] acc_q
);

  AST_TICK_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(ref_en)); // R2

  AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < cur_len); // R8

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |-> $stable(cur_len)); // R8

  AST_ACC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |-> $stable(acc_q)); // R4

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cur_len != '0); // R5

endmodule

bind frac_baud_gen frac_baud_gen_chk #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .baud_tick(baud_tick),
  .cnt_q(cnt_q), .cur_len(cur_len), .acc_q(acc_q)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0;
  logic [13:0] cfg_int = 14'd16;
  logic [2:0]  cfg_frac = 3'd0;
  logic        cfg_wide = 1'b0;
  logic        cfg_load = 1'b0;
  logic        baud_tick;

  always #4 clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .cfg_int(cfg_int),
    .cfg_frac(cfg_frac), .cfg_wide(cfg_wide), .cfg_load(cfg_load),
    .baud_tick(baud_tick)
  );

  typedef struct {
    int    len;
    int    n;
    int    m;
    bit    frac_chk;
    int    seg;
    string req;
  } exp_t;

  exp_t q[$];
  int   tests = 0;
  int   fails = 0;
  int   acc_m = 0;
  int   gap = 1;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  event popped;

  task automatic check(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  function automatic int model_len(int n, int m, bit w);
    int s;
    if (n == 0 && !w) return 1;
    if (n == 1) return 3;
    s = acc_m + m;
    acc_m = s % 8;
    return ((n == 0) ? 16384 : n) + s / 8;
  endfunction

  task automatic push_seg(int n, int m, bit w, int k, int seg, string first_req, string req);
    for (int i = 0; i < k; i++) begin
      exp_t e;
      e.len = model_len(n, m, w);
      e.n = (n == 0 && w) ? 16384 : n;
      e.m = m;
      e.frac_chk = !(n == 0 && !w) && (n != 1) && (m != 0);
      e.seg = seg;
      e.req = (i == 0) ? first_req : req;
      q.push_back(e);
    end
  endtask

  task automatic load_seg(int n, int m, bit w, int k, int seg, string first_req, string req);
    while (q.size() != 1) @(popped);
    @(posedge clk);
    #1;
    cfg_int = n[13:0];
    cfg_frac = m[2:0];
    cfg_wide = w;
    cfg_load = 1'b1;
    push_seg(n, m, w, k, seg, first_req, req);
    @(posedge clk);
    #1;
    cfg_load = 1'b0;
  endtask

  // reference enable generator: one pulse every gap clocks
  initial begin
    int phase;
    phase = 0;
    wait (rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (gap == 0) ref_en = 1'b0;
      else begin
        ref_en = (phase == 0);
        phase = (phase + 1) % gap;
      end
    end
  end

  // monitor: measure each period in reference pulses and score it
  initial begin
    int   refs;
    int   prev_seg;
    bit   prev_ref;
    int   win[$];
    int   sum;
    exp_t e;
    refs = 0;
    prev_seg = -1;
    prev_ref = 1'b0;
    wait (mon_on);
    forever begin
      @(negedge clk);
      if (baud_tick) begin
        check(prev_ref, "R2 tick without ref_en", 0, 1);
        if (q.size() > 0) begin
          e = q.pop_front();
          check(refs == e.len, e.req, refs, e.len);
          if (e.seg != prev_seg) win.delete();
          prev_seg = e.seg;
          if (e.frac_chk) begin
            check(refs >= e.n && refs <= e.n + 1, "R4 period bound", refs, e.n);
            win.push_back(refs);
            if (win.size() > 8) void'(win.pop_front());
            if (win.size() == 8) begin
              sum = 0;
              foreach (win[i]) sum += win[i];
              check(sum == 8 * e.n + e.m, "R4 window sum", sum, 8 * e.n + e.m);
            end
          end
          ->popped;
        end
        refs = 0;
      end
      if (ref_en) refs++;
      prev_ref = ref_en;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(baud_tick == 1'b0, "R1 reset tick low", int'(baud_tick), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    mon_on = 1'b1;
    push_seg(16, 0, 0, 3, 0, "R1", "R1");
    load_seg(2, 0, 0, 4, 1, "R3", "R3");
    load_seg(7, 3, 0, 24, 2, "R9", "R4");
    @(posedge clk); #2; gap = 3;
    load_seg(1, 5, 0, 4, 3, "R6", "R6");
    @(posedge clk); #2; gap = 1;
    load_seg(0, 2, 1, 2, 4, "R7", "R7");
    load_seg(300, 0, 0, 3, 5, "R8", "R8");
    // R8: divisor inputs change without a load; expectations stay at 300
    repeat (5) @(posedge clk);
    #1;
    cfg_int = 14'd9;
    cfg_frac = 3'd7;
    load_seg(0, 6, 0, 6, 6, "R5", "R5");
    while (q.size() != 0) @(popped);
    @(posedge clk); #2; gap = 0;
    repeat (3) @(posedge clk);
    seen = 0;
    repeat (50) begin
      @(negedge clk);
      if (baud_tick) seen++;
    end
    check(seen == 0, "R2 idle ref_en gives no tick", seen, 0);
    finish_run();
  end

endmodule